// File: doc/BRIEF.md
# Precise Exception Commit Unit

This block is the in-order retire stage of a small reorder queue. Instructions take a slot at the queue tail in program order and carry their PC, a destination register number and a write-enable. Execution units report completion out of order by slot index, with an exception class and a cause code. The unit retires at most one finished slot per cycle, always from the head. A retired slot is shown on the retire port, and that is the only point where its register write becomes architectural.

When the head slot has finished with an exception, or an interrupt is pending while the queue holds at least one slot, the unit does not retire the head. It squashes the head and every younger slot, returns the queue to empty and, one cycle later, pulses a redirect with a fixed handler address. The same pulse carries the return PC and the cause. A fault returns to the excepting instruction, a trap returns to the instruction after it, and an abort has no return point. A misprediction flush names the branch slot and drops every slot younger than it, including any exception recorded there.

Top module: `pe_commit_unit`

## Requirements
- R1: A slot retires only from the head, in allocation order, at most one per cycle. `retire_valid_o` is high during the cycle in which the head slot is complete with class none (0), and shows that slot's PC, destination and write-enable. Slots that complete early wait for every older slot.
- R2: The head slot completing with class fault (1) causes a redirect with `epc_o` equal to its own PC, `epc_valid_o`=1 and `abort_o`=0.
- R3: The head slot completing with class trap (2) causes a redirect with `epc_o` equal to its PC plus 4, modulo 2^PC_W.
- R4: The head slot completing with class abort (3) causes a redirect with `abort_o`=1, `epc_valid_o`=0 and `epc_o`=0.
- R5: When several slots hold exceptions, the reported one is the oldest in program order, whatever order they completed in.
- R6: Slots older than the excepting slot retire first. The excepting slot never appears on the retire port. From the redirect cycle onward the queue is empty and the next slot allocated has index 0.
- R7: A flush with slot index f removes every slot younger than f, so the next slot allocated has index f+1. Exceptions recorded on removed slots never cause a redirect.
- R8: A one-cycle pulse on `irq_i` is held until it is taken. It is not taken while the queue is empty. It is taken at the head slot whether or not that slot is complete: the head slot is not retired, `epc_o` is its PC, `ecause_o`=4'hF and `epc_valid_o`=1.
- R9: `redirect_o` is high for exactly one cycle, the cycle after the exception or interrupt is taken. During that cycle `redirect_pc_o` equals the handler address `HANDLER_PC` (default 32'h100).
- R10: `alloc_ready_o` is low when eight slots are in use, while `flush_valid_i` is high, and during the cycle an exception or interrupt is taken. An allocation offered while it is low is dropped.
- R11: When a flush and a head exception occur in the same cycle, the exception wins. The redirect reports that exception and the queue ends empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| alloc_valid_i | input | 1 | Allocate a slot at the tail |
| alloc_pc_i | input | 32 | PC of the allocated instruction |
| alloc_rd_i | input | 5 | Destination register number |
| alloc_wen_i | input | 1 | Instruction writes its destination |
| alloc_ready_o | output | 1 | Allocation will be accepted this cycle |
| alloc_idx_o | output | 3 | Index the next allocation receives |
| cmpl_valid_i | input | 1 | Completion report |
| cmpl_idx_i | input | 3 | Slot that completed |
| cmpl_exc_i | input | 2 | Exception class: 0 none, 1 fault, 2 trap, 3 abort |
| cmpl_cause_i | input | 4 | Cause code |
| flush_valid_i | input | 1 | Misprediction flush |
| flush_idx_i | input | 3 | Mispredicted branch slot; younger slots are removed |
| irq_i | input | 1 | Asynchronous interrupt request |
| retire_valid_o | output | 1 | Head slot retires this cycle |
| retire_pc_o | output | 32 | PC of the retiring slot |
| retire_rd_o | output | 5 | Destination of the retiring slot |
| retire_wen_o | output | 1 | Architectural register write enable |
| redirect_o | output | 1 | One-cycle fetch redirect to the handler |
| redirect_pc_o | output | 32 | Handler address |
| epc_o | output | 32 | Saved return PC |
| ecause_o | output | 4 | Saved cause |
| epc_valid_o | output | 1 | Return PC is resumable |
| abort_o | output | 1 | Non-restartable exception |

## Verification
A wrong head pointer or a stale completion flag shows on the retire port in the very cycle it takes effect: the wrong PC retires, or a slot retires out of order. A wrong tail after a flush shows on `alloc_idx_o` in the next cycle, and later as a younger slot that retires or raises an exception when it should be gone. A wrong exception choice shows one cycle later in the redirect's return PC and cause. An interrupt latch that drops or sticks shows as a missing or repeated redirect pulse. The directed tests therefore sample the retire port every cycle and the redirect fields in the single cycle they are valid.

// File: rtl/pe_commit_pkg.sv
package pe_commit_pkg;
  typedef enum logic [1:0] {
    EXC_NONE  = 2'd0,
    EXC_FAULT = 2'd1,
    EXC_TRAP  = 2'd2,
    EXC_ABORT = 2'd3
  } exc_class_e;
endpackage

// File: rtl/pe_rob_store.sv
module pe_rob_store
  import pe_commit_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int PC_W    = 32,
  parameter int RD_W    = 5,
  parameter int CAUSE_W = 4,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_alloc_i,
  input  logic [IDX_W-1:0]   wr_alloc_idx_i,
  input  logic [PC_W-1:0]    wr_pc_i,
  input  logic [RD_W-1:0]    wr_rd_i,
  input  logic               wr_wen_i,
  input  logic               wr_cmpl_i,
  input  logic [IDX_W-1:0]   wr_cmpl_idx_i,
  input  exc_class_e         wr_exc_i,
  input  logic [CAUSE_W-1:0] wr_cause_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic               rd_done_o,
  output logic [PC_W-1:0]    rd_pc_o,
  output logic [RD_W-1:0]    rd_rd_o,
  output logic               rd_wen_o,
  output exc_class_e         rd_exc_o,
  output logic [CAUSE_W-1:0] rd_cause_o
);
  logic               done_a  [DEPTH];
  logic [PC_W-1:0]    pc_a    [DEPTH];
  logic [RD_W-1:0]    rd_a    [DEPTH];
  logic               wen_a   [DEPTH];
  exc_class_e         exc_a   [DEPTH];
  logic [CAUSE_W-1:0] cause_a [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic               done_q;
    logic [PC_W-1:0]    pc_q;
    logic [RD_W-1:0]    rd_q;
    logic               wen_q;
    exc_class_e         exc_q;
    logic [CAUSE_W-1:0] cause_q;
    logic               hit_alloc, hit_cmpl;

    assign hit_alloc = wr_alloc_i && (wr_alloc_idx_i == IDX_W'(g));
    assign hit_cmpl  = wr_cmpl_i  && (wr_cmpl_idx_i  == IDX_W'(g));

    // status fields: cleared on allocation so stale completions never leak
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        done_q  <= 1'b0;
        exc_q   <= EXC_NONE;
        cause_q <= '0;
      end else if (hit_alloc) begin
        done_q  <= 1'b0;
        exc_q   <= EXC_NONE;
        cause_q <= '0;
      end else if (hit_cmpl) begin
        done_q  <= 1'b1;
        exc_q   <= wr_exc_i;
        cause_q <= wr_cause_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pc_q  <= '0;
        rd_q  <= '0;
        wen_q <= 1'b0;
      end else if (hit_alloc) begin
        pc_q  <= wr_pc_i;
        rd_q  <= wr_rd_i;
        wen_q <= wr_wen_i;
      end
    end

    assign done_a[g]  = done_q;
    assign pc_a[g]    = pc_q;
    assign rd_a[g]    = rd_q;
    assign wen_a[g]   = wen_q;
    assign exc_a[g]   = exc_q;
    assign cause_a[g] = cause_q;
  end

  assign rd_done_o  = done_a[rd_idx_i];
  assign rd_pc_o    = pc_a[rd_idx_i];
  assign rd_rd_o    = rd_a[rd_idx_i];
  assign rd_wen_o   = wen_a[rd_idx_i];
  assign rd_exc_o   = exc_a[rd_idx_i];
  assign rd_cause_o = cause_a[rd_idx_i];
endmodule

// File: rtl/pe_commit_ctrl.sv
module pe_commit_ctrl
  import pe_commit_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int PC_W    = 32,
  parameter int CAUSE_W = 4,
  parameter logic [CAUSE_W-1:0] IRQ_CAUSE = '1,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int PTR_W  = IDX_W + 1
) (
  input  logic [PTR_W-1:0]   count_i,
  input  logic [IDX_W-1:0]   head_idx_i,
  input  logic               head_done_i,
  input  exc_class_e         head_exc_i,
  input  logic [PC_W-1:0]    head_pc_i,
  input  logic [CAUSE_W-1:0] head_cause_i,
  input  logic               irq_pend_i,
  input  logic               alloc_valid_i,
  input  logic               cmpl_valid_i,
  input  logic [IDX_W-1:0]   cmpl_idx_i,
  input  logic               flush_valid_i,
  input  logic [IDX_W-1:0]   flush_idx_i,
  output logic               take_o,
  output logic               take_irq_o,
  output logic               commit_o,
  output logic               alloc_ready_o,
  output logic               alloc_fire_o,
  output logic               cmpl_ok_o,
  output logic               flush_ok_o,
  output logic [IDX_W-1:0]   flush_age_o,
  output logic [PC_W-1:0]    epc_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               epc_valid_o,
  output logic               abort_o
);
  localparam logic [PTR_W-1:0] FULL_CNT = PTR_W'(DEPTH);

  logic nonempty, full, take_exc;
  logic [IDX_W-1:0] cmpl_age;

  assign nonempty = count_i != '0;
  assign full     = count_i == FULL_CNT;

  // head is always the oldest event, so it outranks any flush this cycle
  assign take_exc   = nonempty && head_done_i && (head_exc_i != EXC_NONE);
  assign take_irq_o = nonempty && irq_pend_i && !take_exc;
  assign take_o     = take_exc || take_irq_o;
  assign commit_o   = nonempty && head_done_i && (head_exc_i == EXC_NONE) && !take_irq_o;

  assign alloc_ready_o = !full && !flush_valid_i && !take_o;
  assign alloc_fire_o  = alloc_valid_i && alloc_ready_o;

  assign cmpl_age    = cmpl_idx_i - head_idx_i;
  assign flush_age_o = flush_idx_i - head_idx_i;
  assign cmpl_ok_o   = cmpl_valid_i && !take_o && (PTR_W'(cmpl_age) < count_i);
  assign flush_ok_o  = flush_valid_i && !take_o && (PTR_W'(flush_age_o) < count_i);

  always_comb begin
    epc_o       = head_pc_i;
    cause_o     = head_cause_i;
    epc_valid_o = 1'b1;
    abort_o     = 1'b0;
    if (take_irq_o) begin
      cause_o = IRQ_CAUSE;
    end else begin
      unique case (head_exc_i)
        EXC_TRAP:  epc_o = head_pc_i + PC_W'(4);
        EXC_ABORT: begin
          epc_o       = '0;
          epc_valid_o = 1'b0;
          abort_o     = 1'b1;
        end
        default:   epc_o = head_pc_i;
      endcase
    end
  end
endmodule

// File: rtl/pe_commit_unit.sv
module pe_commit_unit
  import pe_commit_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int PC_W    = 32,
  parameter int RD_W    = 5,
  parameter int CAUSE_W = 4,
  parameter logic [PC_W-1:0]    HANDLER_PC = 32'h0000_0100,
  parameter logic [CAUSE_W-1:0] IRQ_CAUSE  = 4'hF,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int PTR_W  = IDX_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               alloc_valid_i,
  input  logic [PC_W-1:0]    alloc_pc_i,
  input  logic [RD_W-1:0]    alloc_rd_i,
  input  logic               alloc_wen_i,
  output logic               alloc_ready_o,
  output logic [IDX_W-1:0]   alloc_idx_o,
  input  logic               cmpl_valid_i,
  input  logic [IDX_W-1:0]   cmpl_idx_i,
  input  logic [1:0]         cmpl_exc_i,
  input  logic [CAUSE_W-1:0] cmpl_cause_i,
  input  logic               flush_valid_i,
  input  logic [IDX_W-1:0]   flush_idx_i,
  input  logic               irq_i,
  output logic               retire_valid_o,
  output logic [PC_W-1:0]    retire_pc_o,
  output logic [RD_W-1:0]    retire_rd_o,
  output logic               retire_wen_o,
  output logic               redirect_o,
  output logic [PC_W-1:0]    redirect_pc_o,
  output logic [PC_W-1:0]    epc_o,
  output logic [CAUSE_W-1:0] ecause_o,
  output logic               epc_valid_o,
  output logic               abort_o
);
  logic [PTR_W-1:0]   head_q, tail_q, count;
  logic [IDX_W-1:0]   head_idx;
  logic               irq_q;
  logic               head_done, head_wen;
  logic [PC_W-1:0]    head_pc;
  logic [RD_W-1:0]    head_rd;
  exc_class_e         head_exc;
  logic [CAUSE_W-1:0] head_cause;
  logic               take, take_irq, commit, alloc_fire, cmpl_ok, flush_ok;
  logic [IDX_W-1:0]   flush_age;
  logic [PC_W-1:0]    ev_epc;
  logic [CAUSE_W-1:0] ev_cause;
  logic               ev_epc_valid, ev_abort;
  logic               redirect_q, epc_valid_q, abort_q;
  logic [PC_W-1:0]    epc_q;
  logic [CAUSE_W-1:0] cause_q;

  assign count    = tail_q - head_q;
  assign head_idx = head_q[IDX_W-1:0];

  pe_rob_store #(
    .DEPTH(DEPTH), .PC_W(PC_W), .RD_W(RD_W), .CAUSE_W(CAUSE_W)
  ) store_i (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .wr_alloc_i     (alloc_fire),
    .wr_alloc_idx_i (tail_q[IDX_W-1:0]),
    .wr_pc_i        (alloc_pc_i),
    .wr_rd_i        (alloc_rd_i),
    .wr_wen_i       (alloc_wen_i),
    .wr_cmpl_i      (cmpl_ok),
    .wr_cmpl_idx_i  (cmpl_idx_i),
    .wr_exc_i       (exc_class_e'(cmpl_exc_i)),
    .wr_cause_i     (cmpl_cause_i),
    .rd_idx_i       (head_idx),
    .rd_done_o      (head_done),
    .rd_pc_o        (head_pc),
    .rd_rd_o        (head_rd),
    .rd_wen_o       (head_wen),
    .rd_exc_o       (head_exc),
    .rd_cause_o     (head_cause)
  );

  pe_commit_ctrl #(
    .DEPTH(DEPTH), .PC_W(PC_W), .CAUSE_W(CAUSE_W), .IRQ_CAUSE(IRQ_CAUSE)
  ) ctrl_i (
    .count_i       (count),
    .head_idx_i    (head_idx),
    .head_done_i   (head_done),
    .head_exc_i    (head_exc),
    .head_pc_i     (head_pc),
    .head_cause_i  (head_cause),
    .irq_pend_i    (irq_q),
    .alloc_valid_i (alloc_valid_i),
    .cmpl_valid_i  (cmpl_valid_i),
    .cmpl_idx_i    (cmpl_idx_i),
    .flush_valid_i (flush_valid_i),
    .flush_idx_i   (flush_idx_i),
    .take_o        (take),
    .take_irq_o    (take_irq),
    .commit_o      (commit),
    .alloc_ready_o (alloc_ready_o),
    .alloc_fire_o  (alloc_fire),
    .cmpl_ok_o     (cmpl_ok),
    .flush_ok_o    (flush_ok),
    .flush_age_o   (flush_age),
    .epc_o         (ev_epc),
    .cause_o       (ev_cause),
    .epc_valid_o   (ev_epc_valid),
    .abort_o       (ev_abort)
  );

  // pointers carry a wrap bit so full and empty differ
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
    end else if (take) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_q + PTR_W'(commit);
      if (flush_ok) tail_q <= head_q + PTR_W'(flush_age) + PTR_W'(1);
      else          tail_q <= tail_q + PTR_W'(alloc_fire);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= (irq_q && !take_irq) || irq_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_q  <= 1'b0;
      epc_q       <= '0;
      cause_q     <= '0;
      epc_valid_q <= 1'b0;
      abort_q     <= 1'b0;
    end else begin
      redirect_q <= take;
      if (take) begin
        epc_q       <= ev_epc;
        cause_q     <= ev_cause;
        epc_valid_q <= ev_epc_valid;
        abort_q     <= ev_abort;
      end
    end
  end

  assign alloc_idx_o    = tail_q[IDX_W-1:0];
  assign retire_valid_o = commit;
  assign retire_pc_o    = head_pc;
  assign retire_rd_o    = head_rd;
  assign retire_wen_o   = commit && head_wen;
  assign redirect_o     = redirect_q;
  assign redirect_pc_o  = HANDLER_PC;
  assign epc_o          = epc_q;
  assign ecause_o       = cause_q;
  assign epc_valid_o    = epc_valid_q;
  assign abort_o        = abort_q;
endmodule

// File: rtl/pe_commit_unit_chk.sv
module pe_commit_unit_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             alloc_ready_o,
  input logic [IDX_W-1:0] alloc_idx_o,
  input logic             flush_valid_i,
  input logic             retire_valid_o,
  input logic             redirect_o,
  input logic             epc_valid_o,
  input logic             abort_o
);
  p_redirect_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |=> !redirect_o);

  p_abort_no_return_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_o && abort_o) |-> !epc_valid_o);

  p_empty_on_redirect_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> (!retire_valid_o && alloc_idx_o == '0));

  p_flush_blocks_alloc_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_valid_i |-> !alloc_ready_o);

  p_no_retire_before_redirect_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(redirect_o) |-> !$past(retire_valid_o));
endmodule

bind pe_commit_unit pe_commit_unit_chk #(.IDX_W(IDX_W)) chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .alloc_ready_o  (alloc_ready_o),
  .alloc_idx_o    (alloc_idx_o),
  .flush_valid_i  (flush_valid_i),
  .retire_valid_o (retire_valid_o),
  .redirect_o     (redirect_o),
  .epc_valid_o    (epc_valid_o),
  .abort_o        (abort_o)
);

// File: tb/pe_commit_unit_tb_top.sv
`timescale 1ns/1ps
module pe_commit_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        alloc_valid_i = 1'b0;
  logic [31:0] alloc_pc_i = '0;
  logic [4:0]  alloc_rd_i = '0;
  logic        alloc_wen_i = 1'b0;
  logic        alloc_ready_o;
  logic [2:0]  alloc_idx_o;
  logic        cmpl_valid_i = 1'b0;
  logic [2:0]  cmpl_idx_i = '0;
  logic [1:0]  cmpl_exc_i = '0;
  logic [3:0]  cmpl_cause_i = '0;
  logic        flush_valid_i = 1'b0;
  logic [2:0]  flush_idx_i = '0;
  logic        irq_i = 1'b0;
  logic        retire_valid_o;
  logic [31:0] retire_pc_o;
  logic [4:0]  retire_rd_o;
  logic        retire_wen_o;
  logic        redirect_o;
  logic [31:0] redirect_pc_o;
  logic [31:0] epc_o;
  logic [3:0]  ecause_o;
  logic        epc_valid_o;
  logic        abort_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  pe_commit_unit dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .alloc_valid_i(alloc_valid_i), .alloc_pc_i(alloc_pc_i), .alloc_rd_i(alloc_rd_i),
    .alloc_wen_i(alloc_wen_i), .alloc_ready_o(alloc_ready_o), .alloc_idx_o(alloc_idx_o),
    .cmpl_valid_i(cmpl_valid_i), .cmpl_idx_i(cmpl_idx_i), .cmpl_exc_i(cmpl_exc_i),
    .cmpl_cause_i(cmpl_cause_i), .flush_valid_i(flush_valid_i), .flush_idx_i(flush_idx_i),
    .irq_i(irq_i), .retire_valid_o(retire_valid_o), .retire_pc_o(retire_pc_o),
    .retire_rd_o(retire_rd_o), .retire_wen_o(retire_wen_o), .redirect_o(redirect_o),
    .redirect_pc_o(redirect_pc_o), .epc_o(epc_o), .ecause_o(ecause_o),
    .epc_valid_o(epc_valid_o), .abort_o(abort_o)
  );

  typedef struct packed {
    logic [1:0]  exc;
    logic [3:0]  cause;
    logic [31:0] pc;
    logic        exp_ret;
    logic        exp_redir;
    logic [31:0] exp_epc;
    logic        exp_epcv;
    logic        exp_abort;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 4'h0, 32'h0000_1000, 1'b1, 1'b0, 32'h0,         1'b0, 1'b0},
    '{2'd1, 4'h3, 32'h0000_1004, 1'b0, 1'b1, 32'h0000_1004, 1'b1, 1'b0},
    '{2'd2, 4'h8, 32'h0000_2000, 1'b0, 1'b1, 32'h0000_2004, 1'b1, 1'b0},
    '{2'd3, 4'h5, 32'h0000_3000, 1'b0, 1'b1, 32'h0,         1'b0, 1'b1},
    '{2'd1, 4'hD, 32'hFFFF_FFFC, 1'b0, 1'b1, 32'hFFFF_FFFC, 1'b1, 1'b0},
    '{2'd2, 4'h1, 32'hFFFF_FFFC, 1'b0, 1'b1, 32'h0000_0000, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic alloc_one(input logic [31:0] pc, input logic [4:0] rd, output logic [2:0] idx);
    alloc_valid_i = 1'b1; alloc_pc_i = pc; alloc_rd_i = rd; alloc_wen_i = 1'b1;
    idx = alloc_idx_o;
    step();
    alloc_valid_i = 1'b0;
  endtask

  task automatic cmpl_one(input logic [2:0] idx, input logic [1:0] exc, input logic [3:0] cause);
    cmpl_valid_i = 1'b1; cmpl_idx_i = idx; cmpl_exc_i = exc; cmpl_cause_i = cause;
    step();
    cmpl_valid_i = 1'b0;
  endtask

  task automatic chk_redirect(input string req, input logic [31:0] epc, input logic [3:0] cause,
                              input logic epcv, input logic abrt);
    chk({req, " redirect"}, 64'(redirect_o), 64'd1);
    chk("R9 vector", 64'(redirect_pc_o), 64'h100);
    chk({req, " epc"}, 64'(epc_o), 64'(epc));
    chk({req, " cause"}, 64'(ecause_o), 64'(cause));
    chk({req, " epc_valid"}, 64'(epc_valid_o), 64'(epcv));
    chk({req, " abort"}, 64'(abort_o), 64'(abrt));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [2:0] ix [8];
    logic [2:0] tmp;
    string tag;
    repeat (3) step();
    rst_ni = 1'b1;
    step();

    // reset state
    chk("R10 reset ready", 64'(alloc_ready_o), 64'd1);
    chk("R6 reset idx", 64'(alloc_idx_o), 64'd0);
    chk("R1 reset retire", 64'(retire_valid_o), 64'd0);
    chk("R9 reset redirect", 64'(redirect_o), 64'd0);

    // table: single slot per class
    for (int i = 0; i < NVEC; i++) begin
      tag = (VECS[i].exc == 2'd0) ? "R1" : (VECS[i].exc == 2'd1) ? "R2" :
            (VECS[i].exc == 2'd2) ? "R3" : "R4";
      alloc_one(VECS[i].pc, 5'(i + 1), tmp);
      cmpl_one(tmp, VECS[i].exc, VECS[i].cause);
      chk({tag, " retire"}, 64'(retire_valid_o), 64'(VECS[i].exp_ret));
      if (VECS[i].exp_ret) begin
        chk({tag, " retire pc"}, 64'(retire_pc_o), 64'(VECS[i].pc));
        chk({tag, " retire rd"}, 64'(retire_rd_o), 64'(i + 1));
        chk({tag, " retire wen"}, 64'(retire_wen_o), 64'd1);
      end
      step();
      if (VECS[i].exp_redir)
        chk_redirect(tag, VECS[i].exp_epc, VECS[i].cause, VECS[i].exp_epcv, VECS[i].exp_abort);
      else
        chk({tag, " no redirect"}, 64'(redirect_o), 64'd0);
      step();
      chk("R9 single pulse", 64'(redirect_o), 64'd0);
    end

    // R1: out-of-order completion, in-order retirement
    for (int k = 0; k < 3; k++) alloc_one(32'h10 + 32'(4 * k), 5'(k), ix[k]);
    cmpl_one(ix[2], 2'd0, 4'h0);
    chk("R1 wait for head", 64'(retire_valid_o), 64'd0);
    cmpl_one(ix[1], 2'd0, 4'h0);
    chk("R1 wait for head", 64'(retire_valid_o), 64'd0);
    cmpl_one(ix[0], 2'd0, 4'h0);
    for (int k = 0; k < 3; k++) begin
      chk("R1 retire order valid", 64'(retire_valid_o), 64'd1);
      chk("R1 retire order pc", 64'(retire_pc_o), 64'h10 + 64'(4 * k));
      step();
    end
    chk("R1 drained", 64'(retire_valid_o), 64'd0);

    // R5/R6: younger fault completes first, older trap reported
    for (int k = 0; k < 3; k++) alloc_one(32'h40 + 32'(4 * k), 5'(k), ix[k]);
    cmpl_one(ix[2], 2'd1, 4'h2);
    cmpl_one(ix[1], 2'd2, 4'h9);
    chk("R5 head not done", 64'(retire_valid_o), 64'd0);
    chk("R5 no early redirect", 64'(redirect_o), 64'd0);
    cmpl_one(ix[0], 2'd0, 4'h0);
    chk("R6 older retires", 64'(retire_valid_o), 64'd1);
    chk("R6 older pc", 64'(retire_pc_o), 64'h40);
    step();
    chk("R6 excepting not retired", 64'(retire_valid_o), 64'd0);
    step();
    chk_redirect("R5", 32'h48, 4'h9, 1'b1, 1'b0);
    chk("R6 queue reset", 64'(alloc_idx_o), 64'd0);
    step();
    chk("R9 pulse ends", 64'(redirect_o), 64'd0);
    chk("R6 nothing left", 64'(retire_valid_o), 64'd0);

    // R7: wrong-path fault dropped by flush
    for (int k = 0; k < 4; k++) alloc_one(32'h80 + 32'(4 * k), 5'(k), ix[k]);
    cmpl_one(ix[3], 2'd1, 4'h6);
    flush_valid_i = 1'b1; flush_idx_i = ix[1];
    #0;
    chk("R10 flush blocks alloc", 64'(alloc_ready_o), 64'd0);
    step();
    flush_valid_i = 1'b0;
    chk("R7 tail after flush", 64'(alloc_idx_o), 64'(ix[1] + 3'd1));
    cmpl_one(ix[0], 2'd0, 4'h0);
    chk("R7 retire 0", 64'(retire_pc_o), 64'h80);
    cmpl_one(ix[1], 2'd0, 4'h0);
    chk("R7 retire 1", 64'(retire_pc_o), 64'h84);
    step();
    chk("R7 killed not retired", 64'(retire_valid_o), 64'd0);
    step();
    chk("R7 no redirect", 64'(redirect_o), 64'd0);
    alloc_one(32'h90, 5'd9, tmp);
    chk("R7 reuse slot", 64'(tmp), 64'(ix[1] + 3'd1));
    cmpl_one(tmp, 2'd0, 4'h0);
    chk("R7 stale fault gone", 64'(retire_valid_o), 64'd1);
    chk("R7 new pc", 64'(retire_pc_o), 64'h90);
    step();
    step();
    chk("R7 no late redirect", 64'(redirect_o), 64'd0);

    // R8: interrupt held while empty, taken at next boundary
    irq_i = 1'b1;
    step();
    irq_i = 1'b0;
    repeat (3) step();
    chk("R8 ignored while empty", 64'(redirect_o), 64'd0);
    alloc_one(32'hA0, 5'd1, tmp);
    chk("R8 head not retired", 64'(retire_valid_o), 64'd0);
    step();
    chk_redirect("R8", 32'hA0, 4'hF, 1'b1, 1'b0);
    step();
    chk("R8 taken once", 64'(redirect_o), 64'd0);

    // R11: exception and flush in the same cycle
    for (int k = 0; k < 3; k++) alloc_one(32'hC0 + 32'(4 * k), 5'(k), ix[k]);
    cmpl_one(ix[0], 2'd1, 4'h4);
    flush_valid_i = 1'b1; flush_idx_i = ix[0];
    step();
    flush_valid_i = 1'b0;
    chk_redirect("R11", 32'hC0, 4'h4, 1'b1, 1'b0);
    chk("R11 queue empty", 64'(alloc_idx_o), 64'd0);
    step();

    // R10: full queue drops extra allocation; R1 order over wrap
    for (int k = 0; k < 8; k++) alloc_one(32'h200 + 32'(4 * k), 5'(k), ix[k]);
    chk("R10 full not ready", 64'(alloc_ready_o), 64'd0);
    alloc_one(32'hDEAD, 5'd31, tmp);
    for (int k = 7; k >= 1; k--) cmpl_one(ix[k], 2'd0, 4'h0);
    chk("R1 head pending", 64'(retire_valid_o), 64'd0);
    cmpl_one(ix[0], 2'd0, 4'h0);
    for (int k = 0; k < 8; k++) begin
      chk("R1 full drain valid", 64'(retire_valid_o), 64'd1);
      chk("R1 full drain pc", 64'(retire_pc_o), 64'h200 + 64'(4 * k));
      step();
    end
    chk("R10 dropped alloc absent", 64'(retire_valid_o), 64'd0);

    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule